// File: doc/BRIEF.md
# Bus Wake-Up Pattern Detector

This block sits on one channel of a bus transceiver while that channel is in its low-power state. It watches a sampled bus-dominant level coming from the low-power receiver and raises a wake only when it sees a full dominant, recessive, dominant sequence. Each phase must last at least a minimum number of clock cycles, and the whole sequence must end within an overall cycle window. A single dominant level is never enough, so a bus stuck dominant cannot wake the channel.

A glitch filter runs in front of the sequencer. Bus level changes shorter than the filter time are dropped. They cannot break a phase that is in progress, and they never reach the receive output. The receive output is held high (recessive) until a wake has been recognized. After the wake it follows the filtered bus level. Two abort inputs clear the sequence without registering a wake: one says the channel has been switched to its active mode, and the other reports an I/O-supply undervoltage.

All times are parameters in clock cycles. With a 100 MHz clock the defaults are a 0.5 µs filter, a 1 µs minimum phase and a 1 ms window. The minimum phase may be set anywhere from 0.5 µs to 5 µs, and the window from 0.5 ms to 5 ms.

Top module: `wake_seq_detector`

## Requirements
- R1: A filtered dominant phase of at least PHASE_MIN_CYC cycles, then a recessive phase of at least PHASE_MIN_CYC cycles, then a dominant phase of at least PHASE_MIN_CYC cycles, all inside TIMEOUT_CYC cycles, produces exactly one `wake_pulse`, which is one cycle wide. Further patterns produce no more pulses until an abort.
- R2: If any of the three phases is shorter than PHASE_MIN_CYC, no wake is produced and the pattern must start again from its first dominant phase.
- R3: The window starts at the first dominant edge. A pattern that is not complete within TIMEOUT_CYC cycles of that edge produces no wake, and the detector restarts.
- R4: While `in_normal` is high the detector is held cleared. A pattern that was in progress is dropped with no wake, and `wake_pulse` stays low in the following cycle.
- R5: While `io_uv` is high the detector and the filter are held cleared. A pattern that was in progress is dropped with no wake.
- R6: `rx_out` is 1 from reset until a wake has been recognized. It is also 1 in the cycle after `in_normal` or `io_uv` is seen high, and it stays 1 until the next wake.
- R7: After a wake, `rx_out` is the inverse of the filtered dominant level (0 = dominant, 1 = recessive), delayed by one register.
- R8: A change on `bus_dom` that lasts fewer than FILT_CYC cycles is ignored. It does not reach `rx_out` and does not end the current phase.
- R9: A bus held dominant without a break never produces a wake, whatever its length, and `rx_out` stays 1 throughout.
- R10: On `bus_dom`, 1 means dominant and 0 means recessive. Reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_dom | input | 1 | Sampled bus level from the low-power receiver, 1 = dominant |
| in_normal | input | 1 | Channel is in its active mode; clears the detector |
| io_uv | input | 1 | I/O-supply undervoltage; clears the detector and the filter |
| wake_pulse | output | 1 | One-cycle pulse when a wake pattern is recognized |
| rx_out | output | 1 | Receive output: 1 until a wake, then the filtered bus level (0 = dominant) |

## Verification
The bench drives patterns whose phases fall just below or well above the minimum phase length. A detector that checks only the first dominant phase would wake on patterns that have a short recessive phase or a short second dominant phase. Other stimuli send a long recessive gap that runs past the window, and a design that never measures the window would wake on it. Aborts arrive in the middle of a pattern, and a design that keeps the partial state across an abort would wake on the remaining half. Spikes shorter than the filter time are placed inside phases and after a wake; an unfiltered design would either cut a valid phase in two or let the spike show on the receive output. A long clamped-dominant stretch checks that repeated timeouts never produce a wake.

// File: rtl/wkd_pkg.sv
package wkd_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_DOM1,
    WK_REC,
    WK_DOM2,
    WK_WOKE
  } wk_state_t;
endpackage

// File: rtl/wkd_filter.sv
// Level filter: output takes a new bus level only after that level has
// been present for FILT_CYC consecutive samples.
module wkd_filter #(
  parameter int FILT_CYC = 50
) (
  input  logic clk,
  input  logic clr,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      filt    <= 1'b0;
      run_cnt <= '0;
    end else if (raw == filt) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      filt    <= raw;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wkd_satcnt.sv
// Saturating cycle counter with a load-to-one restart.
module wkd_satcnt #(
  parameter int MAXV = 100
) (
  input  logic clk,
  input  logic clr,
  input  logic load1,
  input  logic inc,
  output logic at_max
);
  localparam int CW = $clog2(MAXV + 1);
  localparam logic [CW-1:0] TOP = CW'(MAXV);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (load1)
      cnt <= CW'(1);
    else if (inc && cnt != TOP)
      cnt <= cnt + 1'b1;
  end

  assign at_max = (cnt == TOP);
endmodule

// File: rtl/wkd_seq.sv
// Phase sequencer: dominant, recessive, dominant, checked against a
// per-phase minimum and an overall window.
module wkd_seq
  import wkd_pkg::*;
#(
  parameter int PHASE_MIN_CYC = 100,
  parameter int TIMEOUT_CYC   = 100000
) (
  input  logic clk,
  input  logic clr,
  input  logic filt,
  output logic wake_pulse,
  output logic woke
);
  wk_state_t st_q, st_d;
  logic ph_load, ph_inc, ph_max;
  logic win_load, win_inc, win_exp;
  logic wake_d;

  wkd_satcnt #(.MAXV(PHASE_MIN_CYC)) u_phase (
    .clk(clk), .clr(clr), .load1(ph_load), .inc(ph_inc), .at_max(ph_max)
  );

  wkd_satcnt #(.MAXV(TIMEOUT_CYC)) u_window (
    .clk(clk), .clr(clr), .load1(win_load), .inc(win_inc), .at_max(win_exp)
  );

  always_comb begin
    st_d     = st_q;
    ph_load  = 1'b0;
    ph_inc   = 1'b0;
    win_load = 1'b0;
    wake_d   = 1'b0;
    win_inc  = (st_q == WK_DOM1) || (st_q == WK_REC) || (st_q == WK_DOM2);
    unique case (st_q)
      WK_IDLE: begin
        if (filt) begin
          st_d     = WK_DOM1;
          ph_load  = 1'b1;
          win_load = 1'b1;
        end
      end
      WK_DOM1: begin
        if (win_exp) begin
          st_d = WK_IDLE;
        end else if (!filt) begin
          if (ph_max) begin
            st_d    = WK_REC;
            ph_load = 1'b1;
          end else begin
            st_d = WK_IDLE;
          end
        end else begin
          ph_inc = 1'b1;
        end
      end
      WK_REC: begin
        if (win_exp) begin
          st_d = WK_IDLE;
        end else if (filt) begin
          ph_load = 1'b1;
          if (ph_max) begin
            st_d = WK_DOM2;
          end else begin
            st_d     = WK_DOM1;
            win_load = 1'b1;
          end
        end else begin
          ph_inc = 1'b1;
        end
      end
      WK_DOM2: begin
        if (win_exp) begin
          st_d = WK_IDLE;
        end else if (ph_max) begin
          st_d   = WK_WOKE;
          wake_d = 1'b1;
        end else if (!filt) begin
          st_d = WK_IDLE;
        end else begin
          ph_inc = 1'b1;
        end
      end
      WK_WOKE: st_d = WK_WOKE;
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      st_q       <= WK_IDLE;
      wake_pulse <= 1'b0;
    end else begin
      st_q       <= st_d;
      wake_pulse <= wake_d;
    end
  end

  assign woke = (st_q == WK_WOKE);
endmodule

// File: rtl/wake_seq_detector.sv
module wake_seq_detector #(
  parameter int FILT_CYC      = 50,
  parameter int PHASE_MIN_CYC = 100,
  parameter int TIMEOUT_CYC   = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_dom,
  input  logic in_normal,
  input  logic io_uv,
  output logic wake_pulse,
  output logic rx_out
);
  logic filt_lvl;
  logic woke;
  logic seq_clr;
  logic filt_clr;

  assign seq_clr  = rst | in_normal | io_uv;
  assign filt_clr = rst | io_uv;

  wkd_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .clr(filt_clr), .raw(bus_dom), .filt(filt_lvl)
  );

  wkd_seq #(.PHASE_MIN_CYC(PHASE_MIN_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk(clk), .clr(seq_clr), .filt(filt_lvl), .wake_pulse(wake_pulse), .woke(woke)
  );

  always_ff @(posedge clk) begin
    if (seq_clr)
      rx_out <= 1'b1;
    else
      rx_out <= woke ? ~filt_lvl : 1'b1;
  end
endmodule

// File: rtl/wkd_checker.sv
module wkd_checker (
  input logic clk,
  input logic rst,
  input logic bus_dom,
  input logic in_normal,
  input logic io_uv,
  input logic wake_pulse,
  input logic rx_out,
  input logic filt
);
  logic seen_wake;

  always_ff @(posedge clk) begin
    if (rst || in_normal || io_uv)
      seen_wake <= 1'b0;
    else if (wake_pulse)
      seen_wake <= 1'b1;
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) wake_pulse |=> !wake_pulse); // R1
  AST_NORMAL_NO_WAKE: assert property (@(posedge clk) disable iff (rst) in_normal |=> !wake_pulse); // R4
  AST_UV_NO_WAKE: assert property (@(posedge clk) disable iff (rst) io_uv |=> !wake_pulse); // R5
  AST_ABORT_RX_HIGH: assert property (@(posedge clk) disable iff (rst) (in_normal || io_uv) |=> rx_out); // R6
  AST_RX_LOW_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst) !rx_out |-> seen_wake); // R6
  AST_FILT_FROM_BUS: assert property (@(posedge clk) disable iff (rst) (!$stable(filt) && !$past(io_uv)) |-> ($past(bus_dom) == filt)); // R8
endmodule

bind wake_seq_detector wkd_checker u_chk (
  .clk(clk), .rst(rst), .bus_dom(bus_dom), .in_normal(in_normal), .io_uv(io_uv),
  .wake_pulse(wake_pulse), .rx_out(rx_out), .filt(filt_lvl)
);

// File: tb/sim_wake_seq_detector.sv
module sim_wake_seq_detector;
  localparam int FILT  = 4;
  localparam int PMIN  = 12;
  localparam int TOUT  = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_dom = 1'b0;
  logic in_normal = 1'b0;
  logic io_uv = 1'b0;
  logic wake_pulse;
  logic rx_out;

  int checks = 0;
  int errors = 0;
  int pulse_cnt = 0;
  int base_cnt = 0;
  bit done = 1'b0;

  string exp_tag[$];
  int    exp_val[$];
  event  scn_done;

  always #5 clk = ~clk;

  wake_seq_detector #(.FILT_CYC(FILT), .PHASE_MIN_CYC(PMIN), .TIMEOUT_CYC(TOUT)) u0 (
    .clk(clk), .rst(rst), .bus_dom(bus_dom), .in_normal(in_normal), .io_uv(io_uv),
    .wake_pulse(wake_pulse), .rx_out(rx_out)
  );

  always @(negedge clk) if (!rst && wake_pulse) pulse_cnt++;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the expected wake count of each scenario
  initial begin
    forever begin
      @(scn_done);
      if (exp_tag.size() != 0) begin
        string t;
        int e;
        t = exp_tag.pop_front();
        e = exp_val.pop_front();
        chk(pulse_cnt - base_cnt, e, t);
        base_cnt = pulse_cnt;
      end
    end
  end

  task automatic drv(input logic lvl, input int n);
    bus_dom = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic start_scn(input string tag, input int exp);
    exp_tag.push_back(tag);
    exp_val.push_back(exp);
    bus_dom = 1'b0;
    in_normal = 1'b1;
    repeat (3) @(negedge clk);
    in_normal = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic end_scn();
    drv(1'b0, 30);
    @(posedge clk);
    #1;
    -> scn_done;
    @(negedge clk);
  endtask

  task automatic good_pattern();
    drv(1'b1, 20);
    drv(1'b0, 20);
    drv(1'b1, 20);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_out, 1, "R6 reset rx high");
    chk(wake_pulse, 0, "R6 reset no pulse");

    // R1 basic wake, R7 follow, R8 spike after wake
    start_scn("R1 single wake from valid pattern", 1);
    drv(1'b1, 10);
    chk(rx_out, 1, "R6 rx high before wake");
    drv(1'b1, 10);
    drv(1'b0, 20);
    drv(1'b1, 20);
    drv(1'b0, 20);
    chk(rx_out, 1, "R7 rx recessive after wake");
    drv(1'b1, 10);
    chk(rx_out, 0, "R7 rx dominant after wake");
    drv(1'b1, 5);
    drv(1'b0, 10);
    chk(rx_out, 1, "R7 rx back to recessive");
    drv(1'b1, 2);
    chk(rx_out, 1, "R8 spike not on rx (during)");
    drv(1'b0, 3);
    chk(rx_out, 1, "R8 spike not on rx (after)");
    drv(1'b0, 10);
    good_pattern();
    end_scn();

    // R6 abort after wake returns rx high, R4 restarts
    start_scn("R4 wake before abort counted once", 1);
    good_pattern();
    drv(1'b1, 10);
    chk(rx_out, 0, "R7 rx low while dominant after wake");
    in_normal = 1'b1;
    drv(1'b1, 3);
    chk(rx_out, 1, "R6 rx high after abort");
    in_normal = 1'b0;
    drv(1'b1, 8);
    chk(rx_out, 1, "R4 rx stays high after abort");
    end_scn();

    start_scn("R2 short first dominant", 0);
    drv(1'b1, 8); drv(1'b0, 20); drv(1'b1, 20);
    end_scn();

    start_scn("R2 short recessive", 0);
    drv(1'b1, 20); drv(1'b0, 8); drv(1'b1, 20);
    end_scn();

    start_scn("R2 short second dominant", 0);
    drv(1'b1, 20); drv(1'b0, 20); drv(1'b1, 8);
    end_scn();

    start_scn("R3 pattern past window", 0);
    drv(1'b1, 20); drv(1'b0, 130); drv(1'b1, 20);
    end_scn();

    start_scn("R3 pattern inside window", 1);
    drv(1'b1, 20); drv(1'b0, 60); drv(1'b1, 20);
    end_scn();

    start_scn("R4 normal mode mid pattern", 0);
    drv(1'b1, 20); drv(1'b0, 10);
    in_normal = 1'b1;
    drv(1'b0, 3);
    in_normal = 1'b0;
    drv(1'b0, 10); drv(1'b1, 20);
    end_scn();

    start_scn("R5 undervoltage mid pattern", 0);
    drv(1'b1, 20); drv(1'b0, 10);
    io_uv = 1'b1;
    drv(1'b0, 3);
    io_uv = 1'b0;
    drv(1'b0, 10); drv(1'b1, 20);
    end_scn();

    start_scn("R8 spike inside recessive phase", 1);
    drv(1'b1, 20); drv(1'b0, 9); drv(1'b1, 2); drv(1'b0, 9); drv(1'b1, 20);
    end_scn();

    start_scn("R8 gap inside first dominant", 1);
    drv(1'b1, 9); drv(1'b0, 2); drv(1'b1, 9); drv(1'b0, 20); drv(1'b1, 20);
    end_scn();

    start_scn("R9 clamped dominant", 0);
    drv(1'b1, 200);
    chk(rx_out, 1, "R9 rx high while clamped");
    drv(1'b1, 200);
    chk(rx_out, 1, "R9 rx high after long clamp");
    end_scn();

    start_scn("R10 recessive idle gives no wake", 0);
    drv(1'b0, 100);
    chk(rx_out, 1, "R10 rx high on recessive idle");
    end_scn();

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule